// File: doc/BRIEF.md
# Strap-Triggered Reset Sequencer

This block generates the internal reset and start-up timing for a device that has no reset pin and no power-on detector. One dual-purpose input, the mode strap, does two jobs. Any accepted change of its level starts a new reset sequence, and the level it settles at selects master or slave operation. A master start-up is a low pulse that returns high. A slave start-up is a high pulse that returns low.

The strap input is brought into the clock domain through a synchronizer chain. A run-length filter then rejects any change that does not persist for a minimum number of clock samples. Each accepted change latches the new level as the mode and asserts both a PLL reset and a core reset. The PLL reset is released after a fixed pulse length. The core reset stays asserted through a settle window that covers clock and PLL locking, and `ready_o` goes high when that window ends. An accepted change at any point in the sequence starts it again from the beginning. Before the first accepted change after configuration, the block holds the device in reset whatever the static level of the strap.

Top module: `strap_reset_seq`

## Requirements
- R1: A change of `strap_i` is accepted only when the new level is sampled on at least MIN_PULSE_CYC consecutive rising clock edges. With S = SYNC_STAGES, counting the first edge that samples the new level as edge 1, the outputs show the new sequence after edge S+MIN_PULSE_CYC+1 and not before.
- R2: A change lasting MIN_PULSE_CYC-1 samples or fewer, followed by a return to the previous level, is ignored: `core_rst_o` is not asserted and `master_o` keeps its value.
- R3: A rising and a falling accepted change both start a sequence. After the trigger edge, `pll_rst_o` and `core_rst_o` are 1 and `ready_o` is 0.
- R4: `pll_rst_o` stays 1 for exactly RST_CYC cycles from the trigger edge and then returns to 0.
- R5: `core_rst_o` stays 1 for RST_CYC+SETTLE_CYC cycles from the trigger edge. It falls on the same edge on which `ready_o` rises.
- R6: `master_o` takes the level of `strap_i` after the most recent accepted change (1 = master, 0 = slave). It changes only on the trigger edge.
- R7: An accepted change that arrives during the PLL-reset or settle phase restarts the sequence: `pll_rst_o` asserts again, and `ready_o` rises only a full RST_CYC+SETTLE_CYC cycles after the new trigger.
- R8: From configuration until the first accepted change, `pll_rst_o` = 1, `core_rst_o` = 1, `ready_o` = 0 and `master_o` = 0, for any constant strap level.
- R9: `pll_rst_o` = 1 implies `core_rst_o` = 1, and `ready_o` and `core_rst_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| strap_i | input | 1 | Mode strap, asynchronous; its changes trigger reset and its level selects the mode |
| pll_rst_o | output | 1 | PLL reset, high during the reset pulse phase and before the first trigger |
| core_rst_o | output | 1 | Core reset, high from the trigger until the settle window ends |
| ready_o | output | 1 | High once the sequence has completed |
| master_o | output | 1 | Latched mode: 1 master, 0 slave |

## Verification
The bench builds the block with SYNC_STAGES = 2, MIN_PULSE_CYC = 4, RST_CYC = 6 and SETTLE_CYC = 20. The default settle window of about 100 µs is replaced by one that completes in a few dozen cycles. This lets the bench follow every phase edge exactly, and lets it put a second trigger inside a running settle window. A four-sample filter makes the pass/fail boundary easy to hit: pulses of three samples must be ignored and pulses of four samples accepted.

// File: rtl/strap_reset_pkg.sv
package strap_reset_pkg;

  // Phases of the start-up sequence
  typedef enum logic [1:0] {
    SEQ_WAIT   = 2'd0,  // configured, no trigger seen yet
    SEQ_PLLRST = 2'd1,  // PLL reset pulse running
    SEQ_SETTLE = 2'd2,  // waiting for clock and PLL to settle
    SEQ_READY  = 2'd3   // sequence complete
  } seq_state_e;

  // Bits needed to hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q = '0;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        chain_q[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/strap_filter.sv
module strap_filter
  import strap_reset_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned MIN_PULSE_CYC = 13
) (
  input  logic clk_i,
  input  logic lvl_i,     // synchronized strap level
  output logic level_o,   // filtered strap level
  output logic edge_o     // one-cycle pulse per accepted change
);

  localparam int unsigned PW = cnt_width(SYNC_STAGES + 1);
  localparam int unsigned FW = cnt_width(MIN_PULSE_CYC);
  localparam logic [PW-1:0] PRIME_LAST = PW'(SYNC_STAGES);
  localparam logic [FW-1:0] RUN_LAST   = FW'(MIN_PULSE_CYC - 1);

  logic [PW-1:0] prime_cnt_q = '0;
  logic          primed_q    = 1'b0;
  logic          level_q     = 1'b0;
  logic [FW-1:0] run_q       = '0;
  logic          edge_q      = 1'b0;

  always_ff @(posedge clk_i) begin
    edge_q <= 1'b0;
    if (!primed_q) begin
      // wait until the synchronizer holds a real sample, then adopt it
      // as the reference level without raising an event
      run_q <= '0;
      if (prime_cnt_q == PRIME_LAST) begin
        primed_q <= 1'b1;
        level_q  <= lvl_i;
      end else begin
        prime_cnt_q <= prime_cnt_q + 1'b1;
      end
    end else if (lvl_i != level_q) begin
      if (run_q == RUN_LAST) begin
        level_q <= lvl_i;
        edge_q  <= 1'b1;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign level_o = level_q;
  assign edge_o  = edge_q;

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import strap_reset_pkg::*;
#(
  parameter int unsigned RST_CYC    = 16,
  parameter int unsigned SETTLE_CYC = 12500
) (
  input  logic clk_i,
  input  logic trig_i,
  input  logic level_i,
  output logic pll_rst_o,
  output logic core_rst_o,
  output logic ready_o,
  output logic master_o
);

  localparam int unsigned SPAN = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int unsigned TW   = cnt_width(SPAN);
  localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] SET_LAST = TW'(SETTLE_CYC - 1);

  seq_state_e    state_q  = SEQ_WAIT;
  seq_state_e    state_d;
  logic [TW-1:0] tcnt_q   = '0;
  logic [TW-1:0] tcnt_d;
  logic          master_q = 1'b0;
  logic          pll_q    = 1'b1;
  logic          core_q   = 1'b1;
  logic          ready_q  = 1'b0;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    unique case (state_q)
      SEQ_PLLRST: begin
        if (tcnt_q == RST_LAST) begin
          state_d = SEQ_SETTLE;
          tcnt_d  = '0;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      SEQ_SETTLE: begin
        if (tcnt_q == SET_LAST) begin
          state_d = SEQ_READY;
          tcnt_d  = '0;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: begin
        state_d = state_q;
      end
    endcase
    // a new accepted change always restarts from the top
    if (trig_i) begin
      state_d = SEQ_PLLRST;
      tcnt_d  = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    state_q <= state_d;
    tcnt_q  <= tcnt_d;
    if (trig_i) begin
      master_q <= level_i;
    end
    pll_q   <= (state_d == SEQ_PLLRST) || (state_d == SEQ_WAIT);
    core_q  <= (state_d != SEQ_READY);
    ready_q <= (state_d == SEQ_READY);
  end

  assign pll_rst_o  = pll_q;
  assign core_rst_o = core_q;
  assign ready_o    = ready_q;
  assign master_o   = master_q;

endmodule

// File: rtl/strap_reset_seq.sv
module strap_reset_seq #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned MIN_PULSE_CYC = 13,
  parameter int unsigned RST_CYC       = 16,
  parameter int unsigned SETTLE_CYC    = 12500
) (
  input  logic clk_i,
  input  logic strap_i,
  output logic pll_rst_o,
  output logic core_rst_o,
  output logic ready_o,
  output logic master_o
);

  logic sync_w;
  logic level_w;
  logic edge_w;

  strap_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .d_i   (strap_i),
    .q_o   (sync_w)
  );

  strap_filter #(
    .SYNC_STAGES   (SYNC_STAGES),
    .MIN_PULSE_CYC (MIN_PULSE_CYC)
  ) u_filter (
    .clk_i   (clk_i),
    .lvl_i   (sync_w),
    .level_o (level_w),
    .edge_o  (edge_w)
  );

  rst_sequencer #(
    .RST_CYC    (RST_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .trig_i     (edge_w),
    .level_i    (level_w),
    .pll_rst_o  (pll_rst_o),
    .core_rst_o (core_rst_o),
    .ready_o    (ready_o),
    .master_o   (master_o)
  );

endmodule

// File: rtl/strap_reset_chk.sv
module strap_reset_chk
  import strap_reset_pkg::*;
#(
  parameter int unsigned RST_CYC    = 16,
  parameter int unsigned SETTLE_CYC = 12500
) (
  input logic clk_i,
  input logic trig_i,
  input logic level_i,
  input logic pll_rst_o,
  input logic core_rst_o,
  input logic ready_o,
  input logic master_o
);

  localparam int unsigned GAP_MAX = RST_CYC + SETTLE_CYC + 2;
  localparam int unsigned GW      = cnt_width(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_TOP   = GW'(GAP_MAX);
  localparam logic [GW-1:0] GAP_PLL   = GW'(RST_CYC + 1);
  localparam logic [GW-1:0] GAP_READY = GW'(RST_CYC + SETTLE_CYC + 1);

  logic          armed_q = 1'b0;
  logic [GW-1:0] gap_q   = '0;

  always_ff @(posedge clk_i) begin
    armed_q <= 1'b1;
    if (trig_i) begin
      gap_q <= GW'(1);
    end else if (gap_q != GAP_TOP) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R3
  trig_starts_reset_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    trig_i |=> (pll_rst_o && core_rst_o && !ready_o));

  // R6
  mode_latch_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    trig_i |=> (master_o == $past(level_i)));

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    !trig_i |=> $stable(master_o));

  // R4
  pll_release_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    $fell(pll_rst_o) |-> (gap_q == GAP_PLL));

  // R5
  ready_timing_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    $rose(ready_o) |-> (gap_q == GAP_READY && $fell(core_rst_o)));

  // R9
  pll_within_core_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    pll_rst_o |-> core_rst_o);

  // R9
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    $onehot0({ready_o, core_rst_o}));

endmodule

bind strap_reset_seq strap_reset_chk #(
  .RST_CYC    (RST_CYC),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .trig_i     (edge_w),
  .level_i    (level_w),
  .pll_rst_o  (pll_rst_o),
  .core_rst_o (core_rst_o),
  .ready_o    (ready_o),
  .master_o   (master_o)
);

// File: tb/test_strap_reset_seq.sv
module test_strap_reset_seq;

  localparam int P_SYNC = 2;
  localparam int P_MIN  = 4;
  localparam int P_RST  = 6;
  localparam int P_SET  = 20;
  localparam int LAT    = P_SYNC + P_MIN + 1;   // edges from first sample to trigger
  localparam int FULL   = LAT + P_RST + P_SET;  // edges from first sample to ready

  logic clk = 1'b0;
  logic strap;
  logic pll_rst, core_rst, ready, master;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit saw_rst = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  strap_reset_seq #(
    .SYNC_STAGES   (P_SYNC),
    .MIN_PULSE_CYC (P_MIN),
    .RST_CYC       (P_RST),
    .SETTLE_CYC    (P_SET)
  ) i_strap_reset_seq (
    .clk_i      (clk),
    .strap_i    (strap),
    .pll_rst_o  (pll_rst),
    .core_rst_o (core_rst),
    .ready_o    (ready),
    .master_o   (master)
  );

  // pulse level, pulse width, rest level, expect core reset seen, expect ready, expect master
  typedef struct packed {
    logic       pl;
    logic [7:0] w;
    logic       rl;
    logic       trig;
    logic       rdy;
    logic       mst;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd8,  1'b1, 1'b1, 1'b1, 1'b1},  // low pulse: master
    '{1'b1, 8'd8,  1'b0, 1'b1, 1'b1, 1'b0},  // single fall: slave
    '{1'b1, 8'd3,  1'b0, 1'b0, 1'b1, 1'b0},  // 3-sample high glitch ignored
    '{1'b1, 8'd8,  1'b0, 1'b1, 1'b1, 1'b0},  // high pulse: slave
    '{1'b0, 8'd3,  1'b1, 1'b1, 1'b1, 1'b1},  // single rise: master
    '{1'b0, 8'd4,  1'b1, 1'b1, 1'b1, 1'b1},  // low pulse exactly minimum
    '{1'b0, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1},  // 3-sample low glitch ignored
    '{1'b0, 8'd60, 1'b0, 1'b1, 1'b1, 1'b0}   // fall and stay low: slave
  };

  always @(negedge clk) begin
    if (core_rst) saw_rst = 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    strap = 1'b1;
    @(negedge clk);
    step(10);
    // R8: held in reset with the strap high and no change seen
    check("R8", "pll_rst before trigger", pll_rst, 1);
    check("R8", "core_rst before trigger", core_rst, 1);
    check("R8", "ready before trigger", ready, 0);
    check("R8", "master before trigger", master, 0);

    // table walk: R1 R2 R3 R6
    for (int i = 0; i < NV; i++) begin
      saw_rst = 1'b0;
      strap = VECS[i].pl;
      step(int'(VECS[i].w));
      strap = VECS[i].rl;
      step(50);
      check(VECS[i].trig ? "R3" : "R2", $sformatf("vec %0d reset seen", i), saw_rst, VECS[i].trig);
      check("R5", $sformatf("vec %0d ready", i), ready, VECS[i].rdy);
      check("R6", $sformatf("vec %0d master", i), master, VECS[i].mst);
    end

    // exact phase timing from a rising change (strap is low, ready)
    strap = 1'b1;
    step(LAT - 1);
    check("R1", "no trigger before latency", ready, 1);
    step(1);
    check("R3", "pll_rst at trigger", pll_rst, 1);
    check("R3", "core_rst at trigger", core_rst, 1);
    check("R3", "ready at trigger", ready, 0);
    check("R6", "master after rise", master, 1);
    step(P_RST - 1);
    check("R4", "pll_rst last cycle", pll_rst, 1);
    step(1);
    check("R4", "pll_rst released", pll_rst, 0);
    check("R5", "core_rst in settle", core_rst, 1);
    step(P_SET - 1);
    check("R5", "ready one before end", ready, 0);
    check("R5", "core_rst one before end", core_rst, 1);
    step(1);
    check("R5", "ready at end", ready, 1);
    check("R5", "core_rst at end", core_rst, 0);

    // R7: second change inside the settle window restarts everything
    strap = 1'b0;
    step(LAT + P_RST + 5);
    check("R7", "first run in settle pll", pll_rst, 0);
    check("R7", "first run in settle core", core_rst, 1);
    strap = 1'b1;
    step(LAT);
    check("R7", "pll_rst reasserted", pll_rst, 1);
    check("R7", "master relatched", master, 1);
    step(FULL - (LAT + P_RST + 5) - LAT);
    check("R7", "no ready at old deadline", ready, 0);
    step(FULL - 1 - (FULL - (LAT + P_RST + 5)));
    check("R7", "no ready one before new end", ready, 0);
    step(1);
    check("R7", "ready after full restart", ready, 1);
    check("R9", "core_rst with ready", core_rst, 0);

    // R2: one-sample glitch while ready
    saw_rst = 1'b0;
    strap = 1'b0;
    step(1);
    strap = 1'b1;
    step(30);
    check("R2", "1-sample glitch reset seen", saw_rst, 0);
    check("R2", "1-sample glitch master", master, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule